// File: doc/BRIEF.md
# Instruction Fetch Loop Buffer

This block sits in the fetch stage and keeps a short, contiguous run of the most recently fetched instruction words. It is described by a start address and an occupancy count. A fetch whose address falls inside that run is answered in the same cycle from local storage. A fetch outside it is passed to instruction memory, and the requester holds its request until the reply arrives. Straight-line code, and short forward or backward branches that land inside the run, therefore cost no memory trip.

Each reply from memory is forwarded to the requester in the cycle it arrives. It is also folded into the run. If its address is the next one after the run, it is added at the end, and when the run is full the oldest word is dropped. Any other address discards the run and starts a new one at the reply's address. A flush empties the run. A loop hint carries an iteration count and pins the run in place, so that the body of a tight counted loop keeps hitting while stray replies pass through unbuffered. Each hit at the run's first address uses up one iteration, and at zero the pin is released.

Top module: `loop_fetch_buffer`

## Requirements
- R1: After reset the run is empty: `hit` and `memReqValid` are low while `reqValid` is low, and the first request of any address misses.
- R2: When `reqValid` is high and base <= `reqAddr` < base + count, `hit` is high in the same cycle, `instrData` holds the buffered word for that address, and `memReqValid` stays low. This covers backward and forward branch targets inside the run.
- R3: When `reqValid` is high and `reqAddr` is outside the run, `hit` is low and `memReqValid` is high with `memReqAddr` equal to `reqAddr`, in the same cycle.
- R4: An unpinned reply whose address equals base + count, with count below DEPTH, extends the run by one word. From the next cycle that address hits.
- R5: An unpinned reply whose address equals base + DEPTH, with the run full, drops the oldest word. Base advances by one and the count stays at DEPTH.
- R6: An unpinned reply at any other address, or a reply arriving into an empty run, restarts the run with base equal to the reply address and count one.
- R7: In a cycle with `memRspValid` high and no hit, `instrValid` is high and `instrData` equals `memRspData`.
- R8: `flush` empties the run and releases any loop pin from the next cycle. A reply arriving in the flush cycle is not buffered.
- R9: A `loopArm` pulse loads `loopIters` as the pin count. While the pin count is nonzero, replies leave the run unchanged. Each hit at address base lowers the pin count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the run and drop the loop pin |
| reqValid | input | 1 | Fetch request present |
| reqAddr | input | ADDR_W | Fetch word address |
| hit | output | 1 | Request served from the run |
| instrValid | output | 1 | `instrData` carries a word this cycle |
| instrData | output | DATA_W | Instruction word to decode |
| memReqValid | output | 1 | Request forwarded to instruction memory |
| memReqAddr | output | ADDR_W | Address forwarded to memory |
| memRspValid | input | 1 | Memory reply present |
| memRspAddr | input | ADDR_W | Address of the reply word |
| memRspData | input | DATA_W | Reply instruction word |
| loopArm | input | 1 | Pin the run for a counted loop |
| loopIters | input | ITER_W | Number of passes through the loop head |

## Verification
The assertions assume that a memory reply appears only while a miss is outstanding. They also assume that addresses never wrap past the top of the address space inside a run, and that `flush` and `loopArm` are single-cycle pulses. The stimulus follows these rules by construction. Each miss is answered exactly one cycle later with the address that was requested. All addresses stay far below the address limit, and flush and arm are each driven for one cycle between fetches. Expected hits, data and window motion come from an address-window model in the bench, with instruction words computed as a fixed function of address.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef struct packed {
    logic wrEn;     // store the reply word
    logic advance;  // oldest slot is overwritten, head moves on
    logic clear;    // reset the storage head
  } lfbStrobe_t;
endpackage

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
  import lfb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int ITER_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspAddr,
  input  logic              loopArm,
  input  logic [ITER_W-1:0] loopIters,
  output logic              hit,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [$clog2(DEPTH)-1:0] rdOff,
  output logic [$clog2(DEPTH)-1:0] wrOff,
  output lfbStrobe_t        strb
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int OW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [ADDR_W-1:0] base;
  logic [CW-1:0]     count;
  logic [ITER_W-1:0] pinCnt;

  logic [ADDR_W-1:0] reqOff, rspOff;
  logic inWin, contig, isFull, pinned, take;

  always_comb begin
    reqOff      = reqAddr - base;
    rspOff      = memRspAddr - base;
    inWin       = (count != '0) && (reqOff < ADDR_W'(count));
    contig      = (count != '0) && (rspOff == ADDR_W'(count));
    isFull      = (count == FULL);
    pinned      = (pinCnt != '0);
    take        = memRspValid && !pinned && !flush;
    hit         = reqValid && inWin;
    memReqValid = reqValid && !inWin;
    memReqAddr  = reqAddr;
    rdOff       = reqOff[OW-1:0];
    wrOff       = (contig && !isFull) ? count[OW-1:0] : '0;
    strb.clear  = flush;
    strb.wrEn   = take;
    strb.advance = take && contig && isFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base  <= '0;
      count <= '0;
    end else if (flush) begin
      count <= '0;
    end else if (take) begin
      if (!contig) begin
        base  <= memRspAddr;
        count <= CW'(1);
      end else if (isFull) begin
        base  <= base + ADDR_W'(1);
      end else begin
        count <= count + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       pinCnt <= '0;
    else if (flush)  pinCnt <= '0;
    else if (loopArm) pinCnt <= loopIters;
    else if (hit && pinned && reqOff == '0) pinCnt <= pinCnt - ITER_W'(1);
  end

  AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && memReqValid)); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL); // R5
  AST_FULL_SLIDE: assert property (@(posedge clk) disable iff (!rstN)
    (take && contig && isFull) |=> (count == FULL && base == $past(base) + ADDR_W'(1))); // R5
  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (take && !contig) |=> (count == CW'(1) && base == $past(memRspAddr))); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0 && pinCnt == '0)); // R8
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pinned && !flush) |=> ($stable(base) && $stable(count))); // R9
endmodule

// File: rtl/lfb_data.sv
module lfb_data
  import lfb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  lfbStrobe_t        strb,
  input  logic [$clog2(DEPTH)-1:0] wrOff,
  input  logic [$clog2(DEPTH)-1:0] rdOff,
  input  logic              hit,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              instrValid,
  output logic [DATA_W-1:0] instrData
);
  localparam int OW = $clog2(DEPTH);

  logic [OW-1:0]     head;
  logic [DATA_W-1:0] slots [DEPTH];
  logic [OW-1:0]     wrIdx, rdIdx;

  always_comb begin
    wrIdx      = head + wrOff;
    rdIdx      = head + rdOff;
    instrValid = hit || memRspValid;
    instrData  = hit ? slots[rdIdx] : memRspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             head <= '0;
    else if (strb.clear)   head <= '0;
    else if (strb.advance) head <= head + OW'(1);
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) slots[wrIdx] <= memRspData;
  end

  AST_HEAD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (head == '0)); // R8
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && !hit) |-> (instrValid && instrData == memRspData)); // R7
endmodule

// File: rtl/loop_fetch_buffer.sv
module loop_fetch_buffer
  import lfb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ITER_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              hit,
  output logic              instrValid,
  output logic [DATA_W-1:0] instrData,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspAddr,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              loopArm,
  input  logic [ITER_W-1:0] loopIters
);
  localparam int OW = $clog2(DEPTH);

  lfbStrobe_t    strb;
  logic [OW-1:0] rdOff, wrOff;

  lfb_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .ITER_W(ITER_W)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid),
    .reqAddr(reqAddr), .memRspValid(memRspValid), .memRspAddr(memRspAddr),
    .loopArm(loopArm), .loopIters(loopIters), .hit(hit),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .rdOff(rdOff), .wrOff(wrOff), .strb(strb)
  );

  lfb_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrOff(wrOff), .rdOff(rdOff),
    .hit(hit), .memRspValid(memRspValid), .memRspData(memRspData),
    .instrValid(instrValid), .instrData(instrData)
  );
endmodule

// File: tb/loop_fetch_buffer_test.sv
module loop_fetch_buffer_test;
  localparam int DEPTH = 8, AW = 16, DW = 32, IW = 8;

  logic clk = 0, rstN = 0, flush = 0, reqValid = 0, memRspValid = 0, loopArm = 0;
  logic [AW-1:0] reqAddr = '0, memRspAddr = '0;
  logic [DW-1:0] memRspData = '0;
  logic [IW-1:0] loopIters = '0;
  logic hit, instrValid, memReqValid;
  logic [DW-1:0] instrData;
  logic [AW-1:0] memReqAddr;

  int checks = 0, failures = 0;
  int mBase = 0, mCount = 0, mPin = 0;
  bit done = 0;

  always #2 clk = ~clk;

  loop_fetch_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .ITER_W(IW)) uut (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqAddr(reqAddr),
    .hit(hit), .instrValid(instrValid), .instrData(instrData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspAddr(memRspAddr), .memRspData(memRspData),
    .loopArm(loopArm), .loopIters(loopIters)
  );

  function automatic logic [DW-1:0] wordAt(int a);
    return (DW'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit mIn(int a);
    return mCount != 0 && a >= mBase && a < mBase + mCount;
  endfunction

  task automatic fetch(int a, string tag);
    bit expHit;
    @(negedge clk);
    reqValid = 1; reqAddr = AW'(a);
    #1;
    expHit = mIn(a);
    check(tag, "hit", hit, expHit);
    if (expHit) begin
      check(tag, "hit data", instrData, wordAt(a));
      check(tag, "no mem req", memReqValid, 0);
      if (mPin != 0 && a == mBase) mPin--;
    end else begin
      check(tag, "mem req", memReqValid, 1);
      check(tag, "mem addr", memReqAddr, a);
      @(negedge clk);
      memRspValid = 1; memRspAddr = AW'(a); memRspData = wordAt(a);
      #1;
      check("R7", "fwd valid", instrValid, 1);
      check("R7", "fwd data", instrData, wordAt(a));
      if (mPin == 0) begin
        if (mCount != 0 && a == mBase + mCount) begin
          if (mCount == DEPTH) mBase++;
          else mCount++;
        end else begin
          mBase = a; mCount = 1;
        end
      end
    end
    @(negedge clk);
    reqValid = 0; memRspValid = 0;
  endtask

  task automatic pulseFlush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    mCount = 0; mPin = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    check("R1", "reset hit", hit, 0);
    check("R1", "reset memReq", memReqValid, 0);
    fetch(5, "R1");
    // sequential fill from 5, then slide past capacity
    for (int a = 6; a < 5 + DEPTH; a++) fetch(a, "R4");
    for (int a = 5; a < 5 + DEPTH; a++) fetch(a, "R4");
    for (int a = 5 + DEPTH; a < 9 + DEPTH; a++) fetch(a, "R5");
    check("R5", "base model", mBase, 9);
    fetch(8, "R5");              // evicted: miss, restarts at 8
    check("R6", "model restart", mCount, 1);
    // rebuild a full run 20..27, then branch around inside it
    fetch(20, "R6");
    for (int a = 21; a < 28; a++) fetch(a, "R3");
    fetch(22, "R2"); fetch(27, "R2"); fetch(20, "R2"); fetch(25, "R2");
    fetch(28, "R5");             // contiguous slide
    fetch(20, "R5");             // now outside
    fetch(19, "R3");
    fetch(100, "R6");
    fetch(99, "R6");             // below new base: restart
    fetch(99, "R2");
    pulseFlush();
    fetch(99, "R8");
    // pinned loop over 40..47, two passes through the head
    for (int a = 40; a < 48; a++) fetch(a, "R9");
    @(negedge clk); loopArm = 1; loopIters = 2;
    @(negedge clk); loopArm = 0; mPin = 2;
    for (int a = 40; a < 44; a++) fetch(a, "R9");
    fetch(60, "R9");             // stray miss not buffered
    fetch(40, "R9");
    fetch(44, "R9");
    check("R9", "pin spent", mPin, 0);
    fetch(61, "R9");             // unpinned: restarts
    fetch(40, "R9");
    // pin then flush releases it
    @(negedge clk); loopArm = 1; loopIters = 5;
    @(negedge clk); loopArm = 0; mPin = 5;
    fetch(70, "R9");
    pulseFlush();
    fetch(71, "R8");
    fetch(72, "R8");
    fetch(71, "R8");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule